// File: doc/BRIEF.md
# Execution Mode Summary Register

This block keeps a registered digest of the processor's current execution state for the instruction decoder. It holds its own copies of the few source bits that matter: the long-mode-active enable bit, the protection and paging enables of control register 0, the code segment's privilege level, default-size and 64-bit attributes, the stack segment's default-size attribute, and the virtual-8086 flag. From these it derives the mode, the submode, the privilege level, and the operand, address and stack size codes.

Software-visible writes arrive on one select/data port. Any write to a source refreshes the digest, and so does a write to the digest slot itself, whose data is discarded. A separate refresh pulse also recomputes it. A restore pulse loads every source bit at once from a snapshot vector and recomputes. The digest is driven as one packed word with a one-cycle valid strobe, which forms the decoder port. The individual fields are also brought out as separate ports.

Top module: `mode_summary_unit`

## Requirements
- R1: While reset is asserted and after release, every output field and `word_o` are zero (legacy mode, real submode), and `valid_o` is low.
- R2: With the long-mode-active bit set, `mode_o`=1. The submode is 4 (64-bit) when the code segment 64-bit attribute is set, and 3 (compatibility) otherwise.
- R3: With long mode inactive, `mode_o`=0. The submode is 0 (real) when protection is off, 1 (protected) when protection is on and the VM flag is clear, and 2 (virtual-8086) when both are set. The code segment 64-bit attribute has no effect here.
- R4: `cpl_o` equals the code segment privilege level, `paging_o` equals the paging enable, and `prot_o` equals the protection enable.
- R5: The operand size codes, default/alternate, are 2/1 in the 64-bit submode or when the code segment default-size bit is set, and 1/2 otherwise.
- R6: The address size codes are 3/2 in the 64-bit submode, 2/1 when the code segment default-size bit is set, and 1/2 otherwise.
- R7: The stack size code is 3 in the 64-bit submode, 2 when the stack segment default-size bit is set, and 1 otherwise.
- R8: A write with `wr_sel_i` 0 (long-mode enable, bit 10), 1 (control register 0, protection bit 0 and paging bit 31), 2 (code segment: privilege [1:0], default-size bit 2, 64-bit bit 3), 3 (stack segment, default-size bit 2) or 4 (flags, VM bit 17) updates the source. The digest shows the new value after that same clock edge. `valid_o` is high for exactly the following cycle, and the word holds otherwise.
- R9: A write with `wr_sel_i`=5 discards its data, recomputes from the current sources, and pulses `valid_o`.
- R10: A one-cycle `refresh_i` recomputes from the current sources and pulses `valid_o`, leaving an unchanged state's word unchanged.
- R11: `restore_i` loads all sources from `snap_i` = {lma[8], pg[7], pe[6], vm[5], cs64[4], cs_dsz[3], cs_dpl[2:1], ss_dsz[0]} and recomputes. It takes precedence over a write in the same cycle.
- R12: `word_o` packs, from bit 0 upward: mode[0], submode[3:1], cpl[5:4], paging[6], prot[7], def_op[9:8], alt_op[11:10], def_addr[13:12], alt_addr[15:14], stack[17:16]. Each field equals its separate port.
- R13: A write with `wr_sel_i` 6 or 7 has no effect: no `valid_o` pulse and no change to the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Source write strobe |
| wr_sel_i | input | 3 | Write target select |
| wr_data_i | input | DATA_W | Write data |
| refresh_i | input | 1 | Recompute request |
| restore_i | input | 1 | Load all sources from snapshot |
| snap_i | input | 9 | Source snapshot for restore |
| word_o | output | 18 | Packed digest to the decoder |
| valid_o | output | 1 | One-cycle update strobe |
| mode_o | output | 1 | 0 legacy, 1 long |
| submode_o | output | 3 | 0 real, 1 protected, 2 v86, 3 compat, 4 64-bit |
| cpl_o | output | 2 | Current privilege level |
| paging_o | output | 1 | Paging enabled |
| prot_o | output | 1 | Protection enabled |
| def_op_o | output | 2 | Default operand size code |
| alt_op_o | output | 2 | Alternate operand size code |
| def_addr_o | output | 2 | Default address size code |
| alt_addr_o | output | 2 | Alternate address size code |
| stack_o | output | 2 | Stack size code |

## Verification
A stale or corrupted source bit shows on `word_o` one cycle after the write that should have set it. It appears as a wrong submode, or as size codes that disagree with the mode, for example a 64-bit submode without address code 3. A lost or extra update shows as a missing or spurious `valid_o` pulse in the cycle right after the request. The bench walks through every submode and size-code combination, and the checker ties the strobe to its causes cycle by cycle.

// File: rtl/mode_summary_pkg.sv
package mode_summary_pkg;
  localparam int SIZE_W = 2;

  typedef enum logic [2:0] {
    SEL_EXT     = 3'd0,
    SEL_CR0     = 3'd1,
    SEL_CS      = 3'd2,
    SEL_SS      = 3'd3,
    SEL_FLAGS   = 3'd4,
    SEL_SUMMARY = 3'd5
  } src_sel_e;

  typedef enum logic {
    MODE_LEGACY = 1'b0,
    MODE_LONG   = 1'b1
  } mode_e;

  typedef enum logic [2:0] {
    SUB_REAL   = 3'd0,
    SUB_PROT   = 3'd1,
    SUB_V86    = 3'd2,
    SUB_COMPAT = 3'd3,
    SUB_B64    = 3'd4
  } submode_e;

  typedef struct packed {
    logic       lma;
    logic       pg;
    logic       pe;
    logic       vm;
    logic       cs_long;
    logic       cs_dsz;
    logic [1:0] cs_dpl;
    logic       ss_dsz;
  } src_t;

  typedef struct packed {
    logic [SIZE_W-1:0] stack;
    logic [SIZE_W-1:0] alt_addr;
    logic [SIZE_W-1:0] def_addr;
    logic [SIZE_W-1:0] alt_op;
    logic [SIZE_W-1:0] def_op;
    logic              prot;
    logic              paging;
    logic [1:0]        cpl;
    submode_e          submode;
    mode_e             mode;
  } summary_t;

  localparam int SRC_W     = $bits(src_t);
  localparam int SUMMARY_W = $bits(summary_t);
endpackage

// File: rtl/mode_src_regs.sv
module mode_src_regs
  import mode_summary_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int LMA_BIT     = 10,
  parameter int PE_BIT      = 0,
  parameter int PG_BIT      = 31,
  parameter int DPL_LSB     = 0,
  parameter int CS_DSZ_BIT  = 2,
  parameter int CS_LONG_BIT = 3,
  parameter int SS_DSZ_BIT  = 2,
  parameter int VM_BIT      = 17
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              restore_i,
  input  src_t              snap_i,
  output src_t              src_nxt_o,
  output logic              upd_o
);
  src_t src_q, src_d;
  logic upd;
  logic unused_data;

  assign unused_data = ^wr_data_i;

  always_comb begin
    src_d = src_q;
    upd   = 1'b0;
    if (restore_i) begin
      src_d = snap_i;
      upd   = 1'b1;
    end else if (wr_en_i) begin
      case (wr_sel_i)
        SEL_EXT: begin
          src_d.lma = wr_data_i[LMA_BIT];
          upd       = 1'b1;
        end
        SEL_CR0: begin
          src_d.pe = wr_data_i[PE_BIT];
          src_d.pg = wr_data_i[PG_BIT];
          upd      = 1'b1;
        end
        SEL_CS: begin
          src_d.cs_dpl  = wr_data_i[DPL_LSB +: 2];
          src_d.cs_dsz  = wr_data_i[CS_DSZ_BIT];
          src_d.cs_long = wr_data_i[CS_LONG_BIT];
          upd           = 1'b1;
        end
        SEL_SS: begin
          src_d.ss_dsz = wr_data_i[SS_DSZ_BIT];
          upd          = 1'b1;
        end
        SEL_FLAGS: begin
          src_d.vm = wr_data_i[VM_BIT];
          upd      = 1'b1;
        end
        SEL_SUMMARY: upd = 1'b1;  // data discarded
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) src_q <= '0;
    else         src_q <= src_d;
  end

  assign src_nxt_o = src_d;
  assign upd_o     = upd;
endmodule

// File: rtl/mode_decode.sv
module mode_decode
  import mode_summary_pkg::*;
(
  input  src_t     src_i,
  output summary_t sum_o
);
  logic is64;

  always_comb begin
    sum_o = '0;
    if (src_i.lma) begin
      sum_o.mode    = MODE_LONG;
      sum_o.submode = src_i.cs_long ? SUB_B64 : SUB_COMPAT;
    end else begin
      sum_o.mode    = MODE_LEGACY;
      sum_o.submode = !src_i.pe ? SUB_REAL : (src_i.vm ? SUB_V86 : SUB_PROT);
    end
    is64          = (sum_o.submode == SUB_B64);
    sum_o.cpl     = src_i.cs_dpl;
    sum_o.paging  = src_i.pg;
    sum_o.prot    = src_i.pe;

    if (is64 || src_i.cs_dsz) begin
      sum_o.def_op = 2'd2;
      sum_o.alt_op = 2'd1;
    end else begin
      sum_o.def_op = 2'd1;
      sum_o.alt_op = 2'd2;
    end

    if (is64) begin
      sum_o.def_addr = 2'd3;
      sum_o.alt_addr = 2'd2;
    end else if (src_i.cs_dsz) begin
      sum_o.def_addr = 2'd2;
      sum_o.alt_addr = 2'd1;
    end else begin
      sum_o.def_addr = 2'd1;
      sum_o.alt_addr = 2'd2;
    end

    if (is64)              sum_o.stack = 2'd3;
    else if (src_i.ss_dsz) sum_o.stack = 2'd2;
    else                   sum_o.stack = 2'd1;
  end
endmodule

// File: rtl/mode_summary_reg.sv
module mode_summary_reg
  import mode_summary_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     load_i,
  input  summary_t sum_i,
  output summary_t sum_o,
  output logic     valid_o
);
  summary_t sum_q;
  logic     valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= load_i;
      if (load_i) sum_q <= sum_i;
    end
  end

  assign sum_o   = sum_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/mode_summary_unit.sv
module mode_summary_unit
  import mode_summary_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [2:0]           wr_sel_i,
  input  logic [DATA_W-1:0]    wr_data_i,
  input  logic                 refresh_i,
  input  logic                 restore_i,
  input  logic [SRC_W-1:0]     snap_i,
  output logic [SUMMARY_W-1:0] word_o,
  output logic                 valid_o,
  output logic                 mode_o,
  output logic [2:0]           submode_o,
  output logic [1:0]           cpl_o,
  output logic                 paging_o,
  output logic                 prot_o,
  output logic [SIZE_W-1:0]    def_op_o,
  output logic [SIZE_W-1:0]    alt_op_o,
  output logic [SIZE_W-1:0]    def_addr_o,
  output logic [SIZE_W-1:0]    alt_addr_o,
  output logic [SIZE_W-1:0]    stack_o
);
  src_t     src_nxt;
  logic     src_upd;
  summary_t sum_d, sum_q;

  mode_src_regs #(.DATA_W(DATA_W)) i_src (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_sel_i (wr_sel_i),
    .wr_data_i(wr_data_i),
    .restore_i(restore_i),
    .snap_i   (src_t'(snap_i)),
    .src_nxt_o(src_nxt),
    .upd_o    (src_upd)
  );

  // decode from next-state sources so a write is seen in its own update
  mode_decode i_dec (
    .src_i(src_nxt),
    .sum_o(sum_d)
  );

  mode_summary_reg i_sum (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (src_upd | refresh_i),
    .sum_i  (sum_d),
    .sum_o  (sum_q),
    .valid_o(valid_o)
  );

  assign word_o     = sum_q;
  assign mode_o     = sum_q.mode;
  assign submode_o  = sum_q.submode;
  assign cpl_o      = sum_q.cpl;
  assign paging_o   = sum_q.paging;
  assign prot_o     = sum_q.prot;
  assign def_op_o   = sum_q.def_op;
  assign alt_op_o   = sum_q.alt_op;
  assign def_addr_o = sum_q.def_addr;
  assign alt_addr_o = sum_q.alt_addr;
  assign stack_o    = sum_q.stack;
endmodule

// File: rtl/mode_summary_chk.sv
module mode_summary_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic [2:0]  wr_sel_i,
  input logic        refresh_i,
  input logic        restore_i,
  input logic [17:0] word_o,
  input logic        valid_o,
  input logic        mode_o,
  input logic [2:0]  submode_o,
  input logic        prot_o,
  input logic [1:0]  def_op_o,
  input logic [1:0]  def_addr_o,
  input logic [1:0]  stack_o
);
  logic req;
  assign req = restore_i || refresh_i || (wr_en_i && wr_sel_i <= 3'd5);

  a_r8_valid_after_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req |=> valid_o);
  a_r13_no_spurious_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req |=> !valid_o);
  a_r8_word_holds_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(word_o));
  a_r2_long_submode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o |-> (submode_o == 3'd3 || submode_o == 3'd4));
  a_r3_legacy_submode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_o |-> (submode_o <= 3'd2));
  a_r3_unprotected_is_real: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_o && !prot_o) |-> (submode_o == 3'd0));
  a_r6_b64_sizes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (submode_o == 3'd4) |-> (def_addr_o == 2'd3 && stack_o == 2'd3 && def_op_o == 2'd2));
endmodule

bind mode_summary_unit mode_summary_chk i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_sel_i  (wr_sel_i),
  .refresh_i (refresh_i),
  .restore_i (restore_i),
  .word_o    (word_o),
  .valid_o   (valid_o),
  .mode_o    (mode_o),
  .submode_o (submode_o),
  .prot_o    (prot_o),
  .def_op_o  (def_op_o),
  .def_addr_o(def_addr_o),
  .stack_o   (stack_o)
);

// File: tb/test_mode_summary_unit.sv
module test_mode_summary_unit;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic        refresh = 1'b0;
  logic        restore = 1'b0;
  logic [8:0]  snap = '0;
  logic [17:0] word;
  logic        valid, mode, paging, prot;
  logic [2:0]  submode;
  logic [1:0]  cpl, def_op, alt_op, def_addr, alt_addr, stack;
  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  mode_summary_unit i_mode_summary_unit (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .refresh_i(refresh), .restore_i(restore), .snap_i(snap),
    .word_o(word), .valid_o(valid), .mode_o(mode), .submode_o(submode),
    .cpl_o(cpl), .paging_o(paging), .prot_o(prot), .def_op_o(def_op),
    .alt_op_o(alt_op), .def_addr_o(def_addr), .alt_addr_o(alt_addr), .stack_o(stack)
  );

  function automatic logic [17:0] pk(input int m, input int sub, input int c,
      input int pg, input int pe, input int dop, input int aop,
      input int dad, input int aad, input int stk);
    pk = {stk[1:0], aad[1:0], dad[1:0], aop[1:0], dop[1:0], pe[0], pg[0],
          c[1:0], sub[2:0], m[0]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one update cycle, then check word and strobe, then strobe drop
  task automatic t_update(input string req, input logic [17:0] exp);
    @(negedge clk);
    chk(req, {31'd0, valid}, 32'd1);
    chk(req, {14'd0, word}, {14'd0, exp});
    @(negedge clk);
    chk({req, " strobe"}, {31'd0, valid}, 32'd0);
  endtask

  task automatic t_write(input string req, input logic [2:0] sel,
      input logic [31:0] d, input logic [17:0] exp);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
    chk(req, {31'd0, valid}, 32'd1);
    chk(req, {14'd0, word}, {14'd0, exp});
    @(negedge clk);
    chk({req, " strobe"}, {31'd0, valid}, 32'd0);
  endtask

  task automatic t_reset;
    chk("R1 reset word", {14'd0, word}, 32'd0);
    chk("R1 reset valid", {31'd0, valid}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R1 after release", {13'd0, valid, word}, 32'd0);
  endtask

  task automatic t_refresh(input logic [17:0] exp);
    refresh = 1'b1;
    @(negedge clk);
    refresh = 1'b0;
    chk("R10 refresh valid", {31'd0, valid}, 32'd1);
    chk("R10 refresh word", {14'd0, word}, {14'd0, exp});
    @(negedge clk);
  endtask

  task automatic t_bad_sel(input logic [17:0] exp);
    for (int s = 6; s < 8; s++) begin
      wr_en = 1'b1; wr_sel = 3'(s); wr_data = 32'hFFFF_FFFF;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
      chk("R13 no strobe", {31'd0, valid}, 32'd0);
      chk("R13 word held", {14'd0, word}, {14'd0, exp});
    end
  endtask

  task automatic t_restore;
    // restore wins over a simultaneous lma write; cs64 ignored in legacy
    restore = 1'b1; snap = 9'h05C;
    wr_en = 1'b1; wr_sel = 3'd0; wr_data = 32'h0000_0400;
    @(negedge clk);
    restore = 1'b0; wr_en = 1'b0; wr_data = '0;
    chk("R11 restore valid", {31'd0, valid}, 32'd1);
    chk("R11 restore word", {14'd0, word}, {14'd0, pk(0,1,2,0,1,2,1,2,1,1)});
    @(negedge clk);
  endtask

  task automatic t_fields;
    chk("R12 mode", {31'd0, mode}, 32'd1);
    chk("R12 submode", {29'd0, submode}, 32'd4);
    chk("R12 cpl", {30'd0, cpl}, 32'd2);
    chk("R12 paging", {31'd0, paging}, 32'd0);
    chk("R12 prot", {31'd0, prot}, 32'd1);
    chk("R12 op", {28'd0, def_op, alt_op}, 32'h9);
    chk("R12 addr", {28'd0, def_addr, alt_addr}, 32'hE);
    chk("R12 stack", {30'd0, stack}, 32'd3);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_write("R3 R8 real",        3'd2, 32'h0,         pk(0,0,0,0,0,1,2,1,2,1));
    t_write("R3 R4 protected",   3'd1, 32'h1,         pk(0,1,0,0,1,1,2,1,2,1));
    t_write("R3 v86",            3'd4, 32'h0002_0000, pk(0,2,0,0,1,1,2,1,2,1));
    t_write("R3 v86 clear",      3'd4, 32'h0,         pk(0,1,0,0,1,1,2,1,2,1));
    t_write("R4 paging",         3'd1, 32'h8000_0001, pk(0,1,0,1,1,1,2,1,2,1));
    t_write("R4 R5 R6 cs dsz",   3'd2, 32'h7,         pk(0,1,3,1,1,2,1,2,1,1));
    t_write("R7 ss dsz",         3'd3, 32'h4,         pk(0,1,3,1,1,2,1,2,1,2));
    t_write("R2 compat",         3'd0, 32'h0000_0400, pk(1,3,3,1,1,2,1,2,1,2));
    t_write("R2 R6 R7 b64",      3'd2, 32'h8,         pk(1,4,0,1,1,2,1,3,2,3));
    t_write("R5 compat narrow",  3'd2, 32'h0,         pk(1,3,0,1,1,1,2,1,2,2));
    t_write("R2 b64 again",      3'd2, 32'h8,         pk(1,4,0,1,1,2,1,3,2,3));
    t_write("R9 summary write",  3'd5, 32'hFFFF_FFFF, pk(1,4,0,1,1,2,1,3,2,3));
    t_refresh(pk(1,4,0,1,1,2,1,3,2,3));
    t_bad_sel(pk(1,4,0,1,1,2,1,3,2,3));
    t_restore();
    t_write("R11 R2 lma after restore", 3'd0, 32'h0000_0400, pk(1,4,2,0,1,2,1,3,2,3));
    t_fields();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule